// File: doc/BRIEF.md
# Memory-Encoded Sync Raster Scanout

This block produces a raster video signal without any horizontal or vertical timing counters. A frame memory holds one byte per pixel-clock tick of the whole frame, and a free-running scan address walks through it one location per clock. Each byte read out drives the outputs directly. Six bits carry a 64-colour value, two bits each for red, green and blue. The other two bits carry the horizontal and vertical sync levels. The sync waveform is therefore data, and changing the stored pattern changes the video timing.

The memory has two ports. The scan port reads continuously. The host port can write any location on any cycle without arbitration, and the scan never stalls. Locations that carry sync hold no colour, and colour locations hold zero in both sync bits. The host is expected to write colour locations only and leave the sync bytes as they are.

Each location also has a frame-restart mark. When the scan reaches a marked location, it returns to address 0 on the next step. An optional sequencer, selected by a parameter, fills the memory with a standard sync pattern after reset. It marks the final location and then raises a done flag. The raster size is set by parameters. With 264 ticks per line and 628 lines, the frame has 165792 locations and needs an 18-bit address.

Top module: `memsync_scanout`

## Requirements
- R1: While rst_ni is low, every colour and sync output and init_done_o are 0.
- R2: The byte at the scan address appears on the outputs one clock after that address is presented: bits 5:4 drive red_o, bits 3:2 green_o, bits 1:0 blue_o, bit 6 hsync_o and bit 7 vsync_o, with 1 meaning asserted.
- R3: After init is done, the scan address advances by one location per clock. With no restart mark, it wraps to 0 after location LINE_TICKS*FRAME_LINES-1. The default address width is the ceiling of log2 of that frame size, which is 18 bits for 264 by 628.
- R4: When the scan address holds a location whose restart mark is set, the next scan address is 0, so a mark placed early shortens the frame.
- R5: A host write to the location being scanned in the same cycle leaves that cycle's output at the old byte; the new byte appears on the next pass.
- R6: The init pattern writes colour 0 everywhere. It sets hsync where tick (address mod LINE_TICKS) lies in [HS_START, HS_START+HS_LEN). It sets vsync where line (address div LINE_TICKS) lies in [VS_START, VS_START+VS_LINES). The restart mark is set only on the final location.
- R7: The init sequencer writes one location per clock starting at address 0. init_done_o rises after exactly LINE_TICKS*FRAME_LINES clocks following reset and stays high. The scan address is held at 0 until then.
- R8: Host writes (host_we_i high: byte host_data_i and restart mark host_restart_i stored at host_addr_i) are discarded while init_done_o is low. After that they take effect on any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| host_we_i | input | 1 | Host write strobe |
| host_addr_i | input | ADDR_W | Host write location |
| host_data_i | input | 8 | Byte to store (colour and sync) |
| host_restart_i | input | 1 | Restart mark to store with the byte |
| red_o | output | 2 | Red level |
| green_o | output | 2 | Green level |
| blue_o | output | 2 | Blue level |
| hsync_o | output | 1 | Horizontal sync, 1 = asserted |
| vsync_o | output | 1 | Vertical sync, 1 = asserted |
| init_done_o | output | 1 | Init pattern complete |

## Verification
The bench builds the block with the default reduced raster of 16 ticks by 12 lines, which is 192 locations and an 8-bit address. It uses hsync at ticks 10 to 12 and vsync on lines 9 and 10. With these values the whole init pass, several complete frames, the natural wrap at location 191 and an early restart at location 50 all fit in a few thousand clocks. The hsync and vsync windows are placed inside the line and frame, so both window edges can be observed. Same-cycle collisions and writes issued during init are also exercised against a behavioural model.

// File: rtl/scan_pkg.sv
package scan_pkg;
  // bit 7 vsync, bit 6 hsync, 5:4 red, 3:2 green, 1:0 blue
  typedef struct packed {
    logic       vsync;
    logic       hsync;
    logic [1:0] red;
    logic [1:0] green;
    logic [1:0] blue;
  } pix_t;
endpackage

// File: rtl/scan_addr_ctr.sv
module scan_addr_ctr #(
  parameter int FRAME_SIZE = 192,
  parameter int ADDR_W     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              restart_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(FRAME_SIZE - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         addr_o <= '0;
    else if (!run_i)                     addr_o <= '0;
    else if (restart_i || addr_o == LAST) addr_o <= '0;
    else                                 addr_o <= addr_o + 1'b1;
  end

  assert_in_frame_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_o <= LAST);
  assert_last_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && addr_o == LAST |=> addr_o == '0);
  assert_restart_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && restart_i |=> addr_o == '0);
  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> addr_o == '0);
endmodule

// File: rtl/frame_ram.sv
module frame_ram
  import scan_pkg::*;
#(
  parameter int DEPTH  = 192,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  pix_t              wdata_i,
  input  logic              wmark_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output pix_t              rdata_o,
  output logic              rmark_o
);
  pix_t mem   [DEPTH];
  logic mark  [DEPTH];
  logic in_rng;

  assign in_rng  = 32'(waddr_i) < DEPTH;
  assign rmark_o = mark[raddr_i];

  always_ff @(posedge clk_i) begin
    if (we_i && in_rng) mem[waddr_i] <= wdata_i;
  end

  // restart marks are cleared on reset so an uninitialised frame wraps normally
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mark[i] <= 1'b0;
    end else if (we_i && in_rng) begin
      mark[waddr_i] <= wmark_i;
    end
  end

  // read-first: nonblocking read sees pre-write contents
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/sync_init_seq.sv
module sync_init_seq
  import scan_pkg::*;
#(
  parameter int LINE_TICKS  = 16,
  parameter int FRAME_LINES = 12,
  parameter int HS_START    = 10,
  parameter int HS_LEN      = 3,
  parameter int VS_START    = 9,
  parameter int VS_LINES    = 2,
  parameter int ADDR_W      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output pix_t              data_o,
  output logic              mark_o,
  output logic              done_o
);
  localparam int TW = $clog2(LINE_TICKS + 1);
  localparam int LW = $clog2(FRAME_LINES + 1);
  localparam logic [TW-1:0] T_LAST = TW'(LINE_TICKS - 1);
  localparam logic [TW-1:0] HS_A   = TW'(HS_START);
  localparam logic [TW-1:0] HS_B   = TW'(HS_START + HS_LEN);
  localparam logic [LW-1:0] L_LAST = LW'(FRAME_LINES - 1);
  localparam logic [LW-1:0] VS_A   = LW'(VS_START);
  localparam logic [LW-1:0] VS_B   = LW'(VS_START + VS_LINES);

  logic [TW-1:0] tick_q;
  logic [LW-1:0] line_q;
  logic          last_loc;

  assign last_loc = tick_q == T_LAST && line_q == L_LAST;
  assign we_o     = !done_o;
  assign mark_o   = last_loc;

  always_comb begin
    data_o       = '0;
    data_o.hsync = tick_q >= HS_A && tick_q < HS_B;
    data_o.vsync = line_q >= VS_A && line_q < VS_B;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q <= '0;
      line_q <= '0;
      addr_o <= '0;
      done_o <= 1'b0;
    end else if (!done_o) begin
      addr_o <= addr_o + 1'b1;
      if (last_loc) done_o <= 1'b1;
      if (tick_q == T_LAST) begin
        tick_q <= '0;
        line_q <= line_q + 1'b1;
      end else begin
        tick_q <= tick_q + 1'b1;
      end
    end
  end

  assert_done_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);
  assert_fill_order_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o && $past(we_o) && $past(rst_ni) |-> addr_o == ADDR_W'($past(addr_o) + 1'b1));
endmodule

// File: rtl/memsync_scanout.sv
module memsync_scanout
  import scan_pkg::*;
#(
  parameter int LINE_TICKS  = 16,
  parameter int FRAME_LINES = 12,
  parameter int HS_START    = 10,
  parameter int HS_LEN      = 3,
  parameter int VS_START    = 9,
  parameter int VS_LINES    = 2,
  parameter bit INIT_EN     = 1'b1,
  parameter int ADDR_W      = $clog2(LINE_TICKS * FRAME_LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_we_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [7:0]        host_data_i,
  input  logic              host_restart_i,
  output logic [1:0]        red_o,
  output logic [1:0]        green_o,
  output logic [1:0]        blue_o,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              init_done_o
);
  localparam int FRAME_SIZE = LINE_TICKS * FRAME_LINES;

  logic              init_we, init_mark, init_done;
  logic [ADDR_W-1:0] init_addr;
  pix_t              init_data;

  generate
    if (INIT_EN) begin : g_init
      sync_init_seq #(
        .LINE_TICKS(LINE_TICKS), .FRAME_LINES(FRAME_LINES),
        .HS_START(HS_START), .HS_LEN(HS_LEN),
        .VS_START(VS_START), .VS_LINES(VS_LINES), .ADDR_W(ADDR_W)
      ) u_init (
        .clk_i, .rst_ni,
        .we_o(init_we), .addr_o(init_addr), .data_o(init_data),
        .mark_o(init_mark), .done_o(init_done)
      );
    end else begin : g_no_init
      assign init_we   = 1'b0;
      assign init_addr = '0;
      assign init_data = '0;
      assign init_mark = 1'b0;
      assign init_done = 1'b1;
    end
  endgenerate

  logic              ram_we, ram_wmark, scan_mark;
  logic [ADDR_W-1:0] ram_waddr, scan_addr;
  pix_t              ram_wdata, scan_pix;
  logic              host_ok;

  assign host_ok   = host_we_i && init_done;
  assign ram_we    = init_we || host_ok;
  assign ram_waddr = init_we ? init_addr : host_addr_i;
  assign ram_wdata = init_we ? init_data : pix_t'(host_data_i);
  assign ram_wmark = init_we ? init_mark : host_restart_i;

  frame_ram #(.DEPTH(FRAME_SIZE), .ADDR_W(ADDR_W)) u_ram (
    .clk_i, .rst_ni,
    .we_i(ram_we), .waddr_i(ram_waddr), .wdata_i(ram_wdata), .wmark_i(ram_wmark),
    .raddr_i(scan_addr), .rdata_o(scan_pix), .rmark_o(scan_mark)
  );

  scan_addr_ctr #(.FRAME_SIZE(FRAME_SIZE), .ADDR_W(ADDR_W)) u_ctr (
    .clk_i, .rst_ni, .run_i(init_done), .restart_i(scan_mark), .addr_o(scan_addr)
  );

  assign red_o       = scan_pix.red;
  assign green_o     = scan_pix.green;
  assign blue_o      = scan_pix.blue;
  assign hsync_o     = scan_pix.hsync;
  assign vsync_o     = scan_pix.vsync;
  assign init_done_o = init_done;

  assert_host_gated_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_done_o && host_we_i |-> !ram_we || ram_waddr == init_addr);
  assert_one_writer_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |-> !init_we);
endmodule

// File: tb/tb_memsync_scanout.sv
module tb_memsync_scanout;
  localparam int LT = 16, FL = 12, FS = LT * FL, AW = 8;
  localparam int HSA = 10, HSL = 3, VSA = 9, VSL = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_we = 1'b0, host_restart = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [7:0] host_data = '0;
  logic [1:0] red, green, blue;
  logic hsync, vsync, init_done;

  always #5 clk = ~clk;

  memsync_scanout dut (
    .clk_i(clk), .rst_ni(rst_n), .host_we_i(host_we), .host_addr_i(host_addr),
    .host_data_i(host_data), .host_restart_i(host_restart),
    .red_o(red), .green_o(green), .blue_o(blue), .hsync_o(hsync), .vsync_o(vsync),
    .init_done_o(init_done)
  );

  int checks = 0, errors = 0;
  string phase = "R6";

  // behavioural reference
  logic [7:0] m_mem [FS];
  bit         m_mark [FS];
  int  m_cnt = 0, m_ip = 0;
  bit  m_done = 0, m_valid = 0;
  logic [7:0] m_out = '0;

  function automatic logic [7:0] pat(int a);
    int ln = a / LT, tk = a % LT;
    return {ln >= VSA && ln < VSA + VSL, tk >= HSA && tk < HSA + HSL, 6'b0};
  endfunction

  initial for (int i = 0; i < FS; i++) m_mark[i] = 0;

  always @(posedge clk) if (rst_n) begin
    bit hit;
    m_valid = m_done;
    m_out   = m_mem[m_cnt];
    hit     = m_mark[m_cnt];
    if (m_done) m_cnt = (hit || m_cnt == FS - 1) ? 0 : m_cnt + 1;
    if (!m_done) begin
      m_mem[m_ip]  = pat(m_ip);
      m_mark[m_ip] = (m_ip == FS - 1);
      if (m_ip == FS - 1) m_done = 1; else m_ip++;
    end else if (host_we) begin
      m_mem[host_addr]  = host_data;
      m_mark[host_addr] = host_restart;
    end
  end

  always @(negedge clk) if (rst_n) begin
    checks++;
    if (init_done !== m_done) begin
      errors++;
      $display("FAIL R7 init_done act=%b exp=%b", init_done, m_done);
    end
    if (m_valid) begin
      logic [7:0] act;
      act = {vsync, hsync, red, green, blue};
      checks++;
      if (act !== m_out) begin
        errors++;
        $display("FAIL %s (R2 output byte) act=%h exp=%h", phase, act, m_out);
      end
    end
  end

  task automatic wr(int a, logic [7:0] d, bit r);
    @(negedge clk);
    host_we = 1'b1; host_addr = AW'(a); host_data = d; host_restart = r;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog act=timeout exp=finish");
    finish_run();
  end

  initial begin
    idle(3);
    checks++;
    if ({vsync, hsync, red, green, blue, init_done} !== 9'b0) begin
      errors++;
      $display("FAIL R1 reset outputs act=%b exp=0", {vsync, hsync, red, green, blue, init_done});
    end
    rst_n = 1'b1;
    // R8: write during init must be dropped (colour and early restart)
    phase = "R8";
    idle(5);
    wr(3, 8'hFF, 1'b1);
    wait (init_done);
    phase = "R6";
    idle(2 * FS + 10);
    phase = "R2";
    wr(20, 8'h3F, 0); wr(21, 8'h2A, 0); wr(37, 8'h15, 0); wr(100, 8'h01, 0);
    idle(FS + 20);
    phase = "R5";
    while (m_cnt != 40) @(negedge clk);
    host_we = 1'b1; host_addr = 8'd40; host_data = 8'h33; host_restart = 1'b0;
    @(negedge clk);
    host_we = 1'b0;
    idle(FS + 20);
    phase = "R4";
    wr(50, 8'h0C, 1);
    idle(300);
    wr(50, 8'h0C, 0);
    phase = "R3";
    wr(FS - 1, 8'h00, 0);
    idle(2 * FS + 20);
    finish_run();
  end
endmodule